// File: doc/BRIEF.md
# Cache Line Refill Engine with DRAM Latency Model

This block sits on the memory side of a cache and answers four-word line refills over a bus that is one word wide. The cache presents a line address, the index of the word the processor is waiting for, an organisation mode and an ordering flag. The engine counts out the latency that the selected DRAM organisation would take. It then returns the four words one at a time, each marked with a valid strobe and its index within the line.

Three organisations are modelled. In the split-row mode, one bank is used and every word needs a fresh row opening. In the open-row mode, one bank is used, the first word opens the row and the rest are column reads from it. In the banked mode, four banks are read at once and the words stream out on consecutive cycles. The flag can ask for the waiting word to be sent first, with the others following in wrapping order. An early-restart pulse marks the beat that carries the waiting word, so a stalled pipeline can resume before the line is complete.

Top module: `refill_engine`

## Requirements
- R1: After reset, busy, word_valid, early_restart and refill_done are all low until a request is accepted.
- R2: A request is accepted at a rising edge where req_valid is high and busy is low, and busy is high from the next cycle until the cycle that carries the last word. A request presented while busy is high is ignored: it changes neither the returned words nor the timing, and no refill follows it.
- R3: Mode code 0 (split row): counting the acceptance edge as cycle 0, words appear in cycles 17, 32, 47 and 62, which is 1 address cycle, 15 cycles per row opening for each word, and 1 return cycle.
- R4: Mode code 1 (open row): words appear in cycles 17, 22, 27 and 32, which is 1 + 15 + 3×5 + 1.
- R5: Mode code 2 (banked): words appear in cycles 17, 18, 19 and 20, which is 1 + 15 + 4.
- R6: Mode code 3 is timed exactly as mode code 0.
- R7: With req_crit_first low, the words come out in index order 0, 1, 2, 3 on word_index.
- R8: With req_crit_first high, the first word is the requested one, and each following index is one higher, modulo 4.
- R9: Each word_data equals the 32-bit product of the word address and 32'h9E3779B1, truncated to 32 bits. The word address is {line address, 2-bit word index} with zero extension.
- R10: early_restart is high for exactly one cycle per refill, in the cycle whose word_index equals the requested word index.
- R11: refill_done is high for one cycle, in the cycle just after the last word, and busy is low in that cycle. A request presented in that cycle is accepted.
- R12: Every refill produces exactly four word strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Refill request strobe |
| req_line | input | LINE_AW | Line address to refill |
| req_word | input | 2 | Index of the word the processor waits for |
| req_mode | input | 2 | DRAM organisation: 0 split row, 1 open row, 2 banked, 3 as 0 |
| req_crit_first | input | 1 | Return the requested word first, then wrap |
| busy | output | 1 | Refill in progress |
| word_valid | output | 1 | A returned word is on word_data |
| word_index | output | 2 | Index within the line of the returned word |
| word_data | output | DW | Returned word |
| early_restart | output | 1 | The returned word is the requested one |
| refill_done | output | 1 | One-cycle pulse after the last word |

## Verification
On every cycle, the embedded properties check several rules. A request taken while idle raises busy. No new request is captured while busy. Word strobes and the done pulse never coincide, and early restart only rides on a word strobe. Busy falls exactly into a done pulse. Four strobes are counted before each done. Banked mode streams its words without gaps, and open-row mode leaves idle cycles between words. The exact cycle of each word for every mode, the index order in both orderings, the data values and the back-to-back acceptance in the done cycle depend on the request's parameters. These are shown only by the bench's sweep over all modes, orderings, requested indices and several lines.

// File: rtl/refill_pkg.sv
package refill_pkg;

    typedef enum logic [1:0] {
        RF_MODE_SPLIT_ROW = 2'd0,
        RF_MODE_OPEN_ROW  = 2'd1,
        RF_MODE_BANKED    = 2'd2,
        RF_MODE_ALIAS     = 2'd3
    } rf_mode_e;

    typedef enum logic [1:0] {
        RF_IDLE = 2'd0,
        RF_RUN  = 2'd1,
        RF_DONE = 2'd2
    } rf_state_e;

    typedef struct packed {
        logic valid;
        logic last;
    } rf_beat_t;

    localparam logic [31:0] RF_DATA_MULT = 32'h9E37_79B1;

    // Spacing between successive words for a given organisation.
    function automatic int unsigned rf_gap(rf_mode_e m, int unsigned miss,
                                           int unsigned hit, int unsigned ret);
        case (m)
            RF_MODE_OPEN_ROW: return hit;
            RF_MODE_BANKED:   return ret;
            default:          return miss;
        endcase
    endfunction

    // Cycles from acceptance to the first returned word.
    function automatic int unsigned rf_first(int unsigned addr, int unsigned miss,
                                             int unsigned ret);
        return addr + miss + ret;
    endfunction

endpackage

// File: rtl/refill_beat_timer.sv
module refill_beat_timer
    import refill_pkg::*;
#(
    parameter int unsigned BEATS    = 4,
    parameter int unsigned ADDR_CYC = 1,
    parameter int unsigned ROW_MISS = 15,
    parameter int unsigned ROW_HIT  = 5,
    parameter int unsigned RET_CYC  = 1,
    localparam int unsigned BEAT_W  = $clog2(BEATS),
    localparam int unsigned FIRST   = rf_first(ADDR_CYC, ROW_MISS, RET_CYC),
    localparam int unsigned CW      = $clog2(FIRST + 1) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  rf_mode_e          mode,
    output rf_beat_t          beat,
    output logic [BEAT_W-1:0] beat_num
);

    logic [CW-1:0]     cnt_q;
    logic [BEAT_W-1:0] num_q;
    logic              active_q;
    logic              at_beat;
    int unsigned       gap_cycles;

    always_comb begin
        gap_cycles = rf_gap(mode, ROW_MISS, ROW_HIT, RET_CYC);
        at_beat    = active_q && (cnt_q == '0);
        beat.valid = at_beat;
        beat.last  = at_beat && (num_q == BEAT_W'(BEATS - 1));
        beat_num   = num_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            num_q    <= '0;
            active_q <= 1'b0;
        end else if (start) begin
            cnt_q    <= CW'(FIRST);
            num_q    <= '0;
            active_q <= 1'b1;
        end else if (active_q) begin
            if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end else if (beat.last) begin
                active_q <= 1'b0;
            end else begin
                num_q <= num_q + 1'b1;
                cnt_q <= CW'(gap_cycles - 1);
            end
        end
    end

    // R5
    banked_stream_chk: assert property (@(posedge clk) disable iff (rst)
        (beat.valid && !beat.last && mode == RF_MODE_BANKED) |=> beat.valid);

    // R4
    open_row_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (beat.valid && !beat.last && mode == RF_MODE_OPEN_ROW) |=> !beat.valid);

endmodule

// File: rtl/refill_order.sv
module refill_order #(
    parameter int unsigned BEAT_W = 2
) (
    input  logic              beat_valid,
    input  logic [BEAT_W-1:0] beat_num,
    input  logic [BEAT_W-1:0] req_word,
    input  logic              wrap,
    output logic [BEAT_W-1:0] word_idx,
    output logic              is_req_word
);

    always_comb begin
        word_idx    = wrap ? (beat_num + req_word) : beat_num;
        is_req_word = beat_valid && (word_idx == req_word);
    end

endmodule

// File: rtl/refill_data.sv
module refill_data
    import refill_pkg::*;
#(
    parameter int unsigned LINE_AW = 16,
    parameter int unsigned BEAT_W  = 2,
    parameter int unsigned DW      = 32
) (
    input  logic [LINE_AW-1:0] line,
    input  logic [BEAT_W-1:0]  word_idx,
    output logic [DW-1:0]      data
);

    localparam int unsigned WA_W = LINE_AW + BEAT_W;

    logic [WA_W-1:0] word_addr;
    logic [DW-1:0]   word_addr_ext;

    always_comb begin
        word_addr     = {line, word_idx};
        word_addr_ext = DW'(word_addr);
        data          = word_addr_ext * DW'(RF_DATA_MULT);
    end

endmodule

// File: rtl/refill_engine.sv
module refill_engine
    import refill_pkg::*;
#(
    parameter int unsigned LINE_AW    = 16,
    parameter int unsigned DW         = 32,
    parameter int unsigned LINE_WORDS = 4,
    parameter int unsigned ADDR_CYC   = 1,
    parameter int unsigned ROW_MISS   = 15,
    parameter int unsigned ROW_HIT    = 5,
    parameter int unsigned RET_CYC    = 1,
    localparam int unsigned BEAT_W    = $clog2(LINE_WORDS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [LINE_AW-1:0] req_line,
    input  logic [BEAT_W-1:0]  req_word,
    input  logic [1:0]         req_mode,
    input  logic               req_crit_first,
    output logic               busy,
    output logic               word_valid,
    output logic [BEAT_W-1:0]  word_index,
    output logic [DW-1:0]      word_data,
    output logic               early_restart,
    output logic               refill_done
);

    rf_state_e          state_q;
    logic [LINE_AW-1:0] line_q;
    logic [BEAT_W-1:0]  req_word_q;
    logic               crit_q;
    rf_mode_e           mode_q;
    logic               accept;
    rf_beat_t           beat;
    logic [BEAT_W-1:0]  beat_num;

    assign accept = req_valid && (state_q != RF_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= RF_IDLE;
            line_q     <= '0;
            req_word_q <= '0;
            crit_q     <= 1'b0;
            mode_q     <= RF_MODE_SPLIT_ROW;
        end else begin
            if (accept) begin
                line_q     <= req_line;
                req_word_q <= req_word;
                crit_q     <= req_crit_first;
                mode_q     <= rf_mode_e'(req_mode);
            end
            case (state_q)
                RF_RUN:  if (beat.last) state_q <= RF_DONE;
                default: state_q <= accept ? RF_RUN : RF_IDLE;
            endcase
        end
    end

    refill_beat_timer #(
        .BEATS   (LINE_WORDS),
        .ADDR_CYC(ADDR_CYC),
        .ROW_MISS(ROW_MISS),
        .ROW_HIT (ROW_HIT),
        .RET_CYC (RET_CYC)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start   (accept),
        .mode    (mode_q),
        .beat    (beat),
        .beat_num(beat_num)
    );

    refill_order #(
        .BEAT_W(BEAT_W)
    ) u_order (
        .beat_valid (beat.valid),
        .beat_num   (beat_num),
        .req_word   (req_word_q),
        .wrap       (crit_q),
        .word_idx   (word_index),
        .is_req_word(early_restart)
    );

    refill_data #(
        .LINE_AW(LINE_AW),
        .BEAT_W (BEAT_W),
        .DW     (DW)
    ) u_data (
        .line    (line_q),
        .word_idx(word_index),
        .data    (word_data)
    );

    assign busy        = (state_q == RF_RUN);
    assign word_valid  = beat.valid;
    assign refill_done = (state_q == RF_DONE);

    // Strobe counter used only by the checks below.
    logic [BEAT_W:0] strobes_seen;
    always_ff @(posedge clk) begin
        if (rst || accept) strobes_seen <= '0;
        else if (word_valid) strobes_seen <= strobes_seen + 1'b1;
    end

    // R2
    accept_raises_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> busy);

    // R2
    busy_ignores_req_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && req_valid) |=> ($stable(line_q) && $stable(mode_q)));

    // R11
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (refill_done && !word_valid));

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        refill_done |=> !refill_done);

    // R10
    restart_on_word_chk: assert property (@(posedge clk) disable iff (rst)
        early_restart |-> word_valid);

    // R12
    four_strobes_chk: assert property (@(posedge clk) disable iff (rst)
        refill_done |-> (strobes_seen == (BEAT_W + 1)'(LINE_WORDS)));

    // R11
    strobe_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({word_valid, refill_done}));

endmodule

// File: tb/refill_engine_test.sv
module refill_engine_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [15:0] req_line = '0;
    logic [1:0]  req_word = '0;
    logic [1:0]  req_mode = '0;
    logic        req_crit_first = 1'b0;
    logic        busy, word_valid, early_restart, refill_done;
    logic [1:0]  word_index;
    logic [31:0] word_data;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    refill_engine uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_line(req_line),
        .req_word(req_word), .req_mode(req_mode), .req_crit_first(req_crit_first),
        .busy(busy), .word_valid(word_valid), .word_index(word_index),
        .word_data(word_data), .early_restart(early_restart), .refill_done(refill_done)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    function automatic int gap_of(input logic [1:0] m);
        if (m == 2'd1) return 5;
        if (m == 2'd2) return 1;
        return 15;
    endfunction

    function automatic string tag_of(input logic [1:0] m);
        if (m == 2'd1) return "R4";
        if (m == 2'd2) return "R5";
        if (m == 2'd3) return "R6";
        return "R3";
    endfunction

    task automatic check_idle(input string what);
        vectors++;
        if (busy !== 1'b0 || word_valid !== 1'b0 || early_restart !== 1'b0 || refill_done !== 1'b0) begin
            fails++;
            $display("FAIL %s: idle outputs actual b%0b v%0b r%0b d%0b expected all 0",
                     what, busy, word_valid, early_restart, refill_done);
        end
    endtask

    // One refill. Acceptance edge is cycle 0; outputs sampled at the falling edge of each cycle.
    task automatic run_refill(input logic [1:0] m, input logic crit, input logic [1:0] rw,
                              input logic [15:0] line, input bit pre_driven, input bit chain,
                              input logic [1:0] nm, input logic ncrit, input logic [1:0] nrw,
                              input logic [15:0] nline);
        int gap = gap_of(m);
        int last_t = 17 + 3 * gap;
        int strobes = 0;
        int restarts = 0;
        if (!pre_driven) begin
            @(negedge clk);
            req_valid = 1'b1; req_line = line; req_word = rw;
            req_mode = m; req_crit_first = crit;
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        vectors++;
        if (busy !== 1'b1 || word_valid !== 1'b0) begin
            fails++;
            $display("FAIL R2: cycle 0 busy/valid actual %0b/%0b expected 1/0", busy, word_valid);
        end
        for (int n = 1; n <= last_t + 1; n++) begin
            bit   e_valid, e_busy, e_done, e_rst;
            logic [1:0]  e_idx;
            logic [31:0] e_data, wa;
            int k;
            @(negedge clk);
            e_busy  = (n <= last_t);
            e_done  = (n == last_t + 1);
            e_valid = (n >= 17) && (((n - 17) % gap) == 0) && (n <= last_t);
            k       = (n - 17) / gap;
            e_idx   = crit ? 2'(rw + 2'(k)) : 2'(k);
            wa      = {14'd0, line, e_idx};
            e_data  = wa * 32'h9E37_79B1;
            e_rst   = e_valid && (e_idx == rw);
            vectors++;
            begin
                bit bad = 0;
                if (busy !== e_busy) begin
                    bad = 1;
                    $display("FAIL R2: cycle %0d busy actual %0b expected %0b", n, busy, e_busy);
                end
                if (word_valid !== e_valid) begin
                    bad = 1;
                    $display("FAIL %s: cycle %0d word_valid actual %0b expected %0b",
                             tag_of(m), n, word_valid, e_valid);
                end
                if (refill_done !== e_done) begin
                    bad = 1;
                    $display("FAIL R11: cycle %0d done actual %0b expected %0b", n, refill_done, e_done);
                end
                if (early_restart !== e_rst) begin
                    bad = 1;
                    $display("FAIL R10: cycle %0d restart actual %0b expected %0b", n, early_restart, e_rst);
                end
                if (e_valid && word_valid === 1'b1) begin
                    if (word_index !== e_idx) begin
                        bad = 1;
                        $display("FAIL %s: cycle %0d index actual %0d expected %0d",
                                 crit ? "R8" : "R7", n, word_index, e_idx);
                    end
                    if (word_data !== e_data) begin
                        bad = 1;
                        $display("FAIL R9: cycle %0d data actual %h expected %h", n, word_data, e_data);
                    end
                end
                if (bad) fails++;
            end
            if (word_valid === 1'b1) strobes++;
            if (early_restart === 1'b1) restarts++;
            // R2: a request while busy, with different fields, must be ignored
            if (n == 5) begin
                req_valid = 1'b1; req_line = ~line; req_word = ~rw;
                req_mode = 2'd2; req_crit_first = ~crit;
            end
            if (n == 6) req_valid = 1'b0;
            if (n == last_t + 1 && chain) begin
                // R11: request in the done cycle
                req_valid = 1'b1; req_line = nline; req_word = nrw;
                req_mode = nm; req_crit_first = ncrit;
            end
        end
        vectors++;
        if (strobes != 4 || restarts != 1) begin
            fails++;
            $display("FAIL R12: strobes/restarts actual %0d/%0d expected 4/1", strobes, restarts);
        end
        if (!chain) begin
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                check_idle("R2 ignored request started no refill");
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R1 during reset");
        rst = 1'b0;
        repeat (4) begin
            @(negedge clk);
            check_idle("R1 after reset");
        end
        for (int m = 0; m < 4; m++)
            for (int c = 0; c < 2; c++)
                for (int w = 0; w < 4; w++)
                    for (int l = 0; l < 2; l++)
                        run_refill(2'(m), 1'(c), 2'(w), (l == 0) ? 16'h0000 : 16'hC3A5,
                                   1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0);
        // R11: back-to-back refills accepted in the done cycle
        run_refill(2'd2, 1'b1, 2'd3, 16'h1234, 1'b0, 1'b1, 2'd1, 1'b0, 2'd1, 16'hFFFF);
        run_refill(2'd1, 1'b0, 2'd1, 16'hFFFF, 1'b1, 1'b1, 2'd0, 1'b1, 2'd2, 16'h0F0F);
        run_refill(2'd0, 1'b1, 2'd2, 16'h0F0F, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule